// File: doc/BRIEF.md
# Single-Wire Transmit Line Driver

This block decides, clock by clock, whether the transmitter actively drives a shared single-wire serial line and at what level. The line has an external pull-up and is also used by a receiver and by the far end. Upstream logic supplies four things. The first is the bit level being sent. The second is a flag marking the stop bit. The third is a pair of timing strobes, one at each bit boundary and one at each bit centre. The fourth is a pulse at the start of a frame. The block also reads the sampled line level and two option bits. It returns a pad output enable and a pad output level. Both are registered, so they lag their inputs by one clock.

In the plain policy only zeros are driven, and the pull-up makes the ones. Three other policies help the line rise faster when the pull-up is slow:
- Full push-pull drives both levels for the whole frame.
- Hold-high drives a one until the line is read high or the bit centre arrives, whichever comes first.
- Pulse drives a single clock of high at each zero-to-one step of the sent data.

The policy is captured when the frame starts and stays fixed until the frame ends.

Top module: `swl_tx_driver`

## Requirements
- R1: With cfg_hold=0 and cfg_full=0 (plain policy), a one bit leaves pad_oe=0, so the pull-up makes the high level.
- R2: In every policy, a zero bit inside a frame gives pad_oe=1 and pad_out=0 one clock after the cycle in which tx_bit is 0.
- R3: With cfg_hold=0 and cfg_full=1 (full policy), every one bit of the frame, including the stop bit up to its centre, gives pad_oe=1 and pad_out=1.
- R4: With cfg_hold=1 and cfg_full=0 (hold-high policy), a one bit is driven high starting at its bit_edge cycle. Drive stops once line_in reads 1 or bit_center is asserted, whichever comes first, and never resumes within that bit.
- R5: With cfg_hold=1 and cfg_full=1 (pulse policy), pad_oe=1 and pad_out=1 for exactly one clock after each 0-to-1 change of tx_bit. The high bits are released otherwise. The idle level before a frame counts as 1.
- R6: Drive begins in the clock after frame_start. It is released (pad_oe=0) in the clock after the stop bit's bit_center cycle.
- R7: Outside a frame, pad_oe=0 and pad_out=1, whatever tx_bit and the strobes do.
- R8: The option bits are sampled only in the frame_start cycle. Changes to them during a frame, and any frame_start pulse during a frame, have no effect on that frame.
- R9: Reset gives pad_oe=0 and pad_out=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse in the first cycle of the start bit |
| bit_edge | input | 1 | Strobe in the first cycle of each bit |
| bit_center | input | 1 | Strobe at the centre cycle of each bit |
| tx_bit | input | 1 | Level of the bit being sent (1 when idle) |
| tx_stop | input | 1 | High during the stop bit |
| line_in | input | 1 | Synchronised level read back from the line |
| cfg_full | input | 1 | Option bit: full push-pull drive |
| cfg_hold | input | 1 | Option bit: hold-high drive |
| pad_oe | output | 1 | Pad output enable (registered) |
| pad_out | output | 1 | Pad output level (registered) |

## Verification
In the hold-high policy, two events can end the high drive of a bit in the same clock: the line reading high and the bit centre arriving. The bench provokes this by setting the simulated line to rise exactly in the centre cycle. It also runs two separate cases, one where the line rises before the centre and one where it rises after. In all three cases the drive must stop in the clock after the first of the two events, and must not come back before the next bit. A second overlap is a frame_start pulse and an option change that arrive in the middle of a frame. The bench judges this case by checking that the pulse-policy waveform stays cycle-exact for the rest of the frame.

// File: rtl/swl_drv_pkg.sv
package swl_drv_pkg;
  // encoding is {cfg_hold, cfg_full}
  typedef enum logic [1:0] {
    DRV_PULL  = 2'b00,
    DRV_FULL  = 2'b01,
    DRV_HOLD  = 2'b10,
    DRV_PULSE = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/swl_mode_latch.sv
module swl_mode_latch
  import swl_drv_pkg::*;
#(
  parameter drv_mode_e RESET_MODE = DRV_PULL
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      capture,
  input  logic      cfg_full,
  input  logic      cfg_hold,
  output drv_mode_e mode_now,
  output drv_mode_e mode_q
);
  drv_mode_e mode_r;

  always_ff @(posedge clk) begin
    if (rst) mode_r <= RESET_MODE;
    else if (capture) mode_r <= drv_mode_e'({cfg_hold, cfg_full});
  end

  // the capture cycle already uses the fresh option bits
  assign mode_now = capture ? drv_mode_e'({cfg_hold, cfg_full}) : mode_r;
  assign mode_q   = mode_r;

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(mode_r));
endmodule

// File: rtl/swl_hold_window.sv
module swl_hold_window (
  input  logic clk,
  input  logic rst,
  input  logic enable_w,
  input  logic arm,
  input  logic line_hi,
  input  logic center,
  output logic win_next
);
  logic win_q;

  // open at the bit boundary, close on the first of line-high or centre
  assign win_next = enable_w & (arm | win_q) & ~line_hi & ~center;

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else win_q <= win_next;
  end

  assert_close_on_line_R4: assert property (@(posedge clk) disable iff (rst)
    line_hi |=> !win_q);
  assert_close_on_center_R4: assert property (@(posedge clk) disable iff (rst)
    center |=> !win_q);
endmodule

// File: rtl/swl_rise_pulse.sv
module swl_rise_pulse #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic track,
  input  logic data,
  output logic rise
);
  logic last_q;

  assign rise = track & data & ~last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDLE_LEVEL;
    else last_q <= track ? data : IDLE_LEVEL;
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/swl_tx_driver.sv
module swl_tx_driver
  import swl_drv_pkg::*;
#(
  parameter drv_mode_e RESET_MODE = DRV_PULL,
  parameter logic      IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic bit_edge,
  input  logic bit_center,
  input  logic tx_bit,
  input  logic tx_stop,
  input  logic line_in,
  input  logic cfg_full,
  input  logic cfg_hold,
  output logic pad_oe,
  output logic pad_out
);
  logic      active_q;
  logic      start_ok;
  logic      end_now;
  logic      drive_on;
  drv_mode_e mode_now;
  drv_mode_e mode_q;
  logic      hold_win;
  logic      rise_hit;
  logic      oe_d, out_d;
  logic      oe_q, out_q;

  assign start_ok = frame_start & ~active_q;
  assign end_now  = active_q & bit_center & tx_stop;
  assign drive_on = (active_q | start_ok) & ~end_now;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else if (start_ok) active_q <= 1'b1;
    else if (end_now) active_q <= 1'b0;
  end

  swl_mode_latch #(.RESET_MODE(RESET_MODE)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .capture  (start_ok),
    .cfg_full (cfg_full),
    .cfg_hold (cfg_hold),
    .mode_now (mode_now),
    .mode_q   (mode_q)
  );

  swl_hold_window u_hold (
    .clk      (clk),
    .rst      (rst),
    .enable_w (drive_on & tx_bit & (mode_now == DRV_HOLD)),
    .arm      (bit_edge),
    .line_hi  (line_in),
    .center   (bit_center),
    .win_next (hold_win)
  );

  swl_rise_pulse #(.IDLE_LEVEL(IDLE_LEVEL)) u_rise (
    .clk   (clk),
    .rst   (rst),
    .track (drive_on),
    .data  (tx_bit),
    .rise  (rise_hit)
  );

  always_comb begin
    oe_d  = 1'b0;
    out_d = 1'b1;
    if (drive_on) begin
      if (!tx_bit) begin
        oe_d  = 1'b1;
        out_d = 1'b0;
      end else begin
        case (mode_now)
          DRV_FULL:  oe_d = 1'b1;
          DRV_HOLD:  oe_d = hold_win;
          DRV_PULSE: oe_d = rise_hit;
          default:   oe_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b1;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
    end
  end

  assign pad_oe  = oe_q;
  assign pad_out = out_q;

  assert_plain_no_high_R1: assert property (@(posedge clk) disable iff (rst)
    (pad_oe && pad_out) |-> (mode_q != DRV_PULL));
  assert_low_driven_R2: assert property (@(posedge clk) disable iff (rst)
    (active_q && !tx_bit && !end_now) |=> (pad_oe && !pad_out));
  assert_full_high_R3: assert property (@(posedge clk) disable iff (rst)
    (active_q && tx_bit && !end_now && mode_q == DRV_FULL) |=> (pad_oe && pad_out));
  assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
    end_now |=> !pad_oe);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !frame_start) |=> (!pad_oe && pad_out));
endmodule

// File: tb/swl_tx_driver_test.sv
module swl_tx_driver_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, bit_edge = 1'b0, bit_center = 1'b0;
  logic tx_bit = 1'b1, tx_stop = 1'b0, line_in = 1'b1;
  logic cfg_full = 1'b0, cfg_hold = 1'b0;
  logic pad_oe, pad_out;
  int   n_checks = 0;
  int   n_fail   = 0;

  always #5 clk = ~clk;

  swl_tx_driver uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .bit_edge(bit_edge),
    .bit_center(bit_center), .tx_bit(tx_bit), .tx_stop(tx_stop),
    .line_in(line_in), .cfg_full(cfg_full), .cfg_hold(cfg_hold),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input logic eoe, input logic eout, input string req);
    n_checks++;
    if (pad_oe !== eoe || (eoe && pad_out !== eout) || (!eoe && pad_out !== 1'b1)) begin
      n_fail++;
      $display("FAIL %s t=%0t oe/out actual=%b%b expected=%b%b", req, $time,
               pad_oe, pad_out, eoe, eoe ? eout : 1'b1);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one frame, 4 clocks per bit, centre at position 2; mode is {hold,full}
  task automatic run_frame(input logic [1:0] mode, input logic [15:0] bits,
                           input int n, input int rise_k, input bit scramble,
                           input string tag);
    logic prevb = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic b = bits[i];
      logic st = (i == n - 1);
      for (int pos = 0; pos < 4; pos++) begin
        logic ln = b && (prevb || pos >= rise_k);
        logic eoe, eout;
        string req;
        frame_start = (i == 0 && pos == 0) || (scramble && i == 2 && pos == 1);
        bit_edge    = (pos == 0);
        bit_center  = (pos == 2);
        tx_bit      = b;
        tx_stop     = st;
        line_in     = ln;
        {cfg_hold, cfg_full} = (scramble && !(i == 0 && pos == 0)) ? ~mode : mode;
        tick();
        if (st && pos >= 2) begin
          eoe = 1'b0; eout = 1'b1; req = "R6";
        end else if (!b) begin
          eoe = 1'b1; eout = 1'b0; req = "R2";
        end else begin
          eout = 1'b1; req = tag;
          case (mode)
            2'b01:   eoe = 1'b1;
            2'b10:   eoe = (pos < 2) && !ln;
            2'b11:   eoe = (pos == 0) && !prevb;
            default: eoe = 1'b0;
          endcase
        end
        check(eoe, eout, req);
      end
      prevb = b;
    end
    frame_start = 1'b0; bit_edge = 1'b0; bit_center = 1'b0;
    tx_bit = 1'b1; tx_stop = 1'b0; line_in = 1'b1;
    tick();
    check(1'b0, 1'b1, "R6");
  endtask

  task automatic test_reset();
    rst = 1'b1;
    tick(); tick();
    check(1'b0, 1'b1, "R9");
    rst = 1'b0;
    tick();
    check(1'b0, 1'b1, "R9");
  endtask

  task automatic test_idle();
    // strobes and zero data without a frame must not drive (R7)
    cfg_full = 1'b1; cfg_hold = 1'b0;
    for (int k = 0; k < 6; k++) begin
      bit_edge = (k % 3 == 0); bit_center = (k % 3 == 1);
      tx_bit = k[0]; tx_stop = k[1]; line_in = 1'b0;
      tick();
      check(1'b0, 1'b1, "R7");
    end
    bit_edge = 1'b0; bit_center = 1'b0; tx_bit = 1'b1; tx_stop = 1'b0; line_in = 1'b1;
    cfg_full = 1'b0;
    tick();
  endtask

  task automatic test_plain();   run_frame(2'b00, 16'b110110, 6, 1, 1'b0, "R1"); endtask
  task automatic test_full();    run_frame(2'b01, 16'b110110, 6, 1, 1'b0, "R3"); endtask
  task automatic test_hold_fast();   run_frame(2'b10, 16'b1010110, 7, 1, 1'b0, "R4"); endtask
  task automatic test_hold_slow();   run_frame(2'b10, 16'b1010110, 7, 3, 1'b0, "R4"); endtask
  task automatic test_hold_tie();    run_frame(2'b10, 16'b1010110, 7, 2, 1'b0, "R4"); endtask
  task automatic test_pulse();   run_frame(2'b11, 16'b1011010, 7, 2, 1'b0, "R5"); endtask
  task automatic test_frozen();  run_frame(2'b11, 16'b1010010, 7, 2, 1'b1, "R8"); endtask
  task automatic test_frozen_hold(); run_frame(2'b10, 16'b1100110, 7, 3, 1'b1, "R8"); endtask

  initial begin
    fork
      begin
        test_reset();
        test_idle();
        test_plain();
        test_full();
        test_hold_fast();
        test_hold_slow();
        test_hold_tie();
        test_pulse();
        test_frozen();
        test_frozen_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule